// File: doc/BRIEF.md
# Non-Audio Burst Sync Detector

This block sits behind a digital audio receiver's word extractor. It watches the stream of decoded 16-bit words for the six-word preamble that announces a compressed, non-audio payload. It raises an autodetect flag as soon as the last preamble word is accepted. The flag stays raised while preambles keep arriving. When a full window of frame-start pulses passes with no new preamble, the flag drops.

The block also forms a combined non-audio indicator from the autodetect flag and the receiver's decoded channel-status non-audio bit. Audio samples travel through a one-register pipe that the detector never touches, so any muting is a choice left to the user of the indicator.

Top module: `nad_sync_detect`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge clears the autodetect flag, the partial preamble match, the frame window and the sample pipe, so `auto_detect` and `smp_valid_out` read 0 and `smp_out` reads 0 afterwards.
- R2: The words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F, accepted in that order, set `auto_detect` at the clock edge that accepts 0x4E1F.
- R3: A word is accepted only at a rising edge where `word_valid` is high. Idle cycles between preamble words, whatever `word_data` holds during them, neither break nor advance the match.
- R4: Any accepted word that differs from the expected preamble word abandons the partial match, and a corrupted preamble leaves `auto_detect` low.
- R5: A run of more than four zero words before 0xF872 0x4E1F still counts as a preamble. A zero word accepted right after 0xF872 starts a new attempt.
- R6: After a detection, `auto_detect` stays high through TIMEOUT_FRAMES-1 accepted `frame_start` pulses and falls at the edge of the TIMEOUT_FRAMES-th pulse. The default for TIMEOUT_FRAMES is 4096.
- R7: Each detection restarts the frame window from zero. A detection at the same edge as a `frame_start` pulse wins, and that pulse is not counted.
- R8: `non_audio` is high exactly when `auto_detect` or `cs_nonaudio` is high.
- R9: `smp_out` and `smp_valid_out` repeat `smp_in` and `smp_valid_in` one clock later, unchanged, whatever the state of the detector.
- R10: Once the window has expired, the frame counter holds at its limit. Further frame pulses keep `auto_detect` low, and a later preamble sets it again.
- R11: A reset in the middle of a preamble discards the partial match, so the remaining words alone do not set `auto_detect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_valid | input | 1 | Strobe qualifying `word_data` |
| word_data | input | 16 | Decoded receiver word |
| frame_start | input | 1 | One-cycle pulse per received frame |
| cs_nonaudio | input | 1 | Decoded channel-status non-audio bit |
| smp_valid_in | input | 1 | Audio sample strobe in |
| smp_in | input | SAMPLE_W | Audio sample in |
| smp_valid_out | output | 1 | Audio sample strobe out, delayed one clock |
| smp_out | output | SAMPLE_W | Audio sample out, delayed one clock and unchanged |
| auto_detect | output | 1 | Preamble-based non-audio autodetect flag |
| non_audio | output | 1 | Combined non-audio indicator |

## Verification
The hardest situation to reach is the exact edge of the frame window. The flag must survive TIMEOUT_FRAMES-1 pulses and fall on the next one. A second preamble must restart the count, even when it lands in the same cycle as a frame pulse. The bench holds `frame_start` high for a counted run of cycles so that the window boundary falls on a known edge. It then checks the flag one pulse before and at the limit, after a retrigger placed partway through the window, and after a final preamble word that coincides with a pulse. The overlap cases in the matcher (long zero runs, and a zero right after 0xF872) are covered by sweeping the number of leading zeros and every single-word corruption of the preamble.

// File: rtl/nad_pkg.sv
// Package nad_pkg
// Shared constants for the non-audio burst sync detector: the preamble
// length, its word width and the word expected at each position.
// Assumes the preamble is a run of zero words followed by nonzero words.
package nad_pkg;
    localparam int SYNC_LEN  = 6;
    localparam int SYNC_W    = 16;
    localparam int ZERO_RUN  = 4;   // leading zero words in the preamble
    localparam int SYNC_IDXW = $clog2(SYNC_LEN + 1);

    typedef logic [SYNC_W-1:0]    sync_word_t;
    typedef logic [SYNC_IDXW-1:0] sync_idx_t;

    // Expected preamble word at a given position.
    function automatic sync_word_t sync_word(input sync_idx_t idx);
        case (idx)
            sync_idx_t'(ZERO_RUN):     sync_word = 16'hF872;
            sync_idx_t'(ZERO_RUN + 1): sync_word = 16'h4E1F;
            default:                   sync_word = '0;
        endcase
    endfunction
endpackage

// File: rtl/nad_sync_matcher.sv
// Module nad_sync_matcher
// Tracks how much of the six-word preamble has been seen on the word
// stream. A word is taken only when word_valid is high. A mismatch falls
// back to the longest preamble prefix that is still a suffix of the words
// seen. Because the preamble starts with a zero run and ends with nonzero
// words, that prefix is either the zero run (stay), one zero, or empty.
// Assumes: hit is consumed in the same cycle (combinational output).
module nad_sync_matcher
    import nad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_valid,
    input  sync_word_t word_data,
    output logic       hit
);
    localparam sync_idx_t LAST_IDX = sync_idx_t'(SYNC_LEN - 1);
    localparam sync_idx_t RUN_IDX  = sync_idx_t'(ZERO_RUN);

    sync_idx_t idx_q;
    sync_idx_t idx_d;
    logic      hit_c;

    // Next match position and completion strobe.
    always_comb begin
        idx_d = idx_q;
        hit_c = 1'b0;
        if (word_valid) begin
            if (word_data == sync_word(idx_q)) begin
                if (idx_q == LAST_IDX) begin
                    hit_c = 1'b1;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + sync_idx_t'(1);
                end
            end else if (word_data == '0) begin
                idx_d = (idx_q == RUN_IDX) ? RUN_IDX : sync_idx_t'(1);
            end else begin
                idx_d = '0;
            end
        end
    end

    // Match position register.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign hit = hit_c;
endmodule

// File: rtl/nad_frame_timer.sv
// Module nad_frame_timer
// Holds the autodetect flag. A hit sets it and zeroes the frame counter.
// Each frame_start pulse advances the counter, which saturates at
// TIMEOUT_FRAMES. The pulse that brings the counter to the limit clears
// the flag. A hit takes priority over a frame pulse in the same cycle.
// Assumes TIMEOUT_FRAMES >= 1.
module nad_frame_timer #(
    parameter int TIMEOUT_FRAMES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit,
    input  logic frame_start,
    output logic flag
);
    localparam int               CNT_W   = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_FRAMES);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TIMEOUT_FRAMES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    // Frame window counter and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_MAX;
            flag_q <= 1'b0;
        end else if (sync_hit) begin
            cnt_q  <= '0;
            flag_q <= 1'b1;
        end else if (frame_start && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_END) flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/nad_sample_pipe.sv
// Module nad_sample_pipe
// One-register pass-through for audio samples and their strobe. The
// detector has no path into it, so samples leave exactly as they entered.
module nad_sample_pipe #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    // Sample and strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/nad_sync_detect.sv
// Module nad_sync_detect (top)
// Non-audio burst sync detector: a preamble matcher on the decoded word
// stream, a frame-window timer holding the autodetect flag, a combined
// non-audio indicator, and an untouched sample pass-through.
// Assumes frame_start and word_valid are single-cycle strobes in the clk
// domain. Reset is synchronous and active low.
module nad_sync_detect #(
    parameter int SAMPLE_W       = 24,
    parameter int TIMEOUT_FRAMES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [15:0]         word_data,
    input  logic                frame_start,
    input  logic                cs_nonaudio,
    input  logic                smp_valid_in,
    input  logic [SAMPLE_W-1:0] smp_in,
    output logic                smp_valid_out,
    output logic [SAMPLE_W-1:0] smp_out,
    output logic                auto_detect,
    output logic                non_audio
);
    logic sync_hit;

    nad_sync_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .hit        (sync_hit)
    );

    nad_frame_timer #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_hit    (sync_hit),
        .frame_start (frame_start),
        .flag        (auto_detect)
    );

    nad_sample_pipe #(
        .SAMPLE_W (SAMPLE_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid_in),
        .in_data   (smp_in),
        .out_valid (smp_valid_out),
        .out_data  (smp_out)
    );

    // Combined indicator from autodetect and channel status.
    always_comb non_audio = auto_detect | cs_nonaudio;
endmodule

// File: rtl/nad_sync_detect_chk.sv
// Module nad_sync_detect_chk
// Temporal checks on the detector, bound into nad_sync_detect.
module nad_sync_detect_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_start,
    input logic                cs_nonaudio,
    input logic                sync_hit,
    input logic                smp_valid_in,
    input logic [SAMPLE_W-1:0] smp_in,
    input logic                smp_valid_out,
    input logic [SAMPLE_W-1:0] smp_out,
    input logic                auto_detect,
    input logic                non_audio
);
    // R2: a completed preamble sets the flag at the next edge.
    assert_hit_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> auto_detect);

    // R2: the flag only rises after a completed preamble.
    assert_rise_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_detect) |-> $past(sync_hit));

    // R6: the flag only falls on a frame pulse without a hit.
    assert_fall_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(auto_detect) |-> ($past(frame_start) && !$past(sync_hit)));

    // R7: with neither a hit nor a frame pulse the flag holds.
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !sync_hit) |=> $stable(auto_detect));

    // R8: channel status alone raises the indicator.
    assert_cs_drives_indicator_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_nonaudio |-> non_audio);

    // R9: samples pass one clock later, unchanged.
    assert_sample_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (smp_out == $past(smp_in) && smp_valid_out == $past(smp_valid_in)));
endmodule

bind nad_sync_detect nad_sync_detect_chk #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .cs_nonaudio   (cs_nonaudio),
    .sync_hit      (sync_hit),
    .smp_valid_in  (smp_valid_in),
    .smp_in        (smp_in),
    .smp_valid_out (smp_valid_out),
    .smp_out       (smp_out),
    .auto_detect   (auto_detect),
    .non_audio     (non_audio)
);

// File: tb/nad_sync_detect_tb.sv
module nad_sync_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_W   = 24;
    localparam int TMO        = 4096;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                word_valid = 1'b0;
    logic [15:0]         word_data = '0;
    logic                frame_start = 1'b0;
    logic                cs_nonaudio = 1'b0;
    logic                smp_valid_in = 1'b0;
    logic [SAMPLE_W-1:0] smp_in = '0;
    logic                smp_valid_out;
    logic [SAMPLE_W-1:0] smp_out;
    logic                auto_detect;
    logic                non_audio;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nad_sync_detect #(.SAMPLE_W(SAMPLE_W), .TIMEOUT_FRAMES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .frame_start(frame_start), .cs_nonaudio(cs_nonaudio),
        .smp_valid_in(smp_valid_in), .smp_in(smp_in),
        .smp_valid_out(smp_valid_out), .smp_out(smp_out),
        .auto_detect(auto_detect), .non_audio(non_audio)
    );

    function automatic logic [15:0] pat(input int i);
        pat = (i == 4) ? 16'hF872 : (i == 5) ? 16'h4E1F : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [15:0] w);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = 16'hBEEF;
    endtask

    task automatic send_sync();
        for (int i = 0; i < 6; i++) send(pat(i));
    endtask

    task automatic frames(input int n);
        frame_start = 1'b1;
        repeat (n) @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] vals [4];
        vals[0] = 16'h0001; vals[1] = 16'h0000; vals[2] = 16'hF872; vals[3] = 16'h4E1F;

        // R1: reset state
        @(negedge clk); smp_in = 24'hABCDEF; smp_valid_in = 1'b1;
        do_reset();
        smp_valid_in = 1'b0; smp_in = '0;
        chk("R1 flag", auto_detect, 0);
        chk("R1 valid_out", smp_valid_out, 0);
        chk("R1 sample_out", smp_out, 0);
        chk("R8 indicator idle", non_audio, 0);
        cs_nonaudio = 1'b1; #1;
        chk("R8 indicator from cs", non_audio, 1);
        cs_nonaudio = 1'b0;

        // R2 / R5: sweep leading zero count
        for (int z = 0; z <= 8; z++) begin
            do_reset();
            for (int k = 0; k < z; k++) send(16'h0000);
            send(16'hF872);
            send(16'h4E1F);
            chk("R2 R5 zero sweep", auto_detect, (z >= 4) ? 1 : 0);
        end

        // R4: every single-word corruption, then recovery
        for (int p = 0; p < 6; p++) begin
            for (int v = 0; v < 4; v++) begin
                if (vals[v] == pat(p)) continue;
                do_reset();
                for (int i = 0; i < 6; i++) send((i == p) ? vals[v] : pat(i));
                chk("R4 corrupted preamble", auto_detect, 0);
                send_sync();
                chk("R4 recovery detect", auto_detect, 1);
                chk("R8 indicator from flag", non_audio, 1);
            end
        end

        // R3: idle gaps with misleading data
        do_reset();
        for (int i = 0; i < 6; i++) begin
            send(pat(i));
            word_data = pat(5 - i);
            repeat (i + 1) @(negedge clk);
            if (i == 4) chk("R3 no early flag", auto_detect, 0);
        end
        chk("R3 gapped preamble", auto_detect, 1);

        // R5: zero right after F872 restarts
        do_reset();
        for (int k = 0; k < 4; k++) send(16'h0000);
        send(16'hF872);
        for (int k = 0; k < 4; k++) send(16'h0000);
        send(16'hF872);
        send(16'h4E1F);
        chk("R5 restart after F872", auto_detect, 1);

        // R6 / R10: timeout boundary and saturation
        do_reset();
        send_sync();
        frames(TMO - 1);
        chk("R6 before limit", auto_detect, 1);
        frames(1);
        chk("R6 at limit", auto_detect, 0);
        chk("R8 indicator after timeout", non_audio, 0);
        frames(10);
        chk("R10 stays low", auto_detect, 0);
        send_sync();
        chk("R10 detect again", auto_detect, 1);
        frames(TMO - 1);
        chk("R10 fresh window", auto_detect, 1);

        // R7: retrigger restarts window
        do_reset();
        send_sync();
        frames(3000);
        send_sync();
        frames(3000);
        chk("R7 retrigger holds", auto_detect, 1);
        frames(TMO - 3001);
        chk("R7 before new limit", auto_detect, 1);
        frames(1);
        chk("R7 at new limit", auto_detect, 0);

        // R7: hit and frame pulse in the same cycle
        do_reset();
        send_sync();
        frames(4000);
        for (int i = 0; i < 5; i++) send(pat(i));
        frame_start = 1'b1;
        send(pat(5));
        frame_start = 1'b0;
        frames(TMO - 1);
        chk("R7 same-cycle hit wins", auto_detect, 1);
        frames(1);
        chk("R7 same-cycle limit", auto_detect, 0);

        // R9: pass-through with flag low and high
        for (int f = 0; f < 2; f++) begin
            do_reset();
            if (f == 1) send_sync();
            for (int i = 0; i < 32; i++) begin
                logic [SAMPLE_W-1:0] s;
                s = SAMPLE_W'(i * 32'h0051F3A7 + f);
                smp_in = s; smp_valid_in = i[0];
                @(negedge clk);
                chk("R9 sample", smp_out, s);
                chk("R9 strobe", smp_valid_out, i[0]);
            end
            smp_valid_in = 1'b0;
            chk("R9 flag untouched", auto_detect, f);
        end

        // R11: reset in the middle of a preamble
        do_reset();
        for (int i = 0; i < 5; i++) send(pat(i));
        do_reset();
        send(16'h4E1F);
        chk("R11 partial match cleared", auto_detect, 0);
        send_sync();
        do_reset();
        chk("R1 reset clears flag", auto_detect, 0);

        finish_run();
    end
endmodule